// File: doc/BRIEF.md
# Fully Associative Page Translation Buffer

The block holds a set of page translations, each linking a 20-bit virtual page to a 32-bit low word that carries a physical page and attribute bits. Every slot is compared against the query at once. Software fills and inspects the buffer through a maintenance port with four operations: write to a named slot, write to a slot that hardware picks, read a named slot, and probe for a virtual page. A separate lookup port translates one 32-bit virtual address per cycle for a load or a store. For each lookup it reports the physical address and the no-cache attribute, or a miss, invalid or modify fault.

Matching uses only the virtual page. The valid bit is never part of the compare, so an entry with valid clear still claims its page and raises the invalid fault. Hardware never changes the dirty bit; software sets it to grant write permission. Virtual pages with the top bit set lie in a region that is never translated. An entry that holds such a page can never match. The buffer is therefore cleared by loading each slot with its own distinct page from that region, and reset does exactly this.

Top module: `xlat_tlb`

## Requirements
- R1: While and after reset, all outputs are zero. Slot i holds high word (0x80000+i)<<12 and low word 0, and the hardware slot selector holds ENTRIES-1.
- R2: Every maintenance request raises mnt_done for exactly the next cycle. mnt_op encodes 0 = write to mnt_index, 1 = write to the hardware slot, 2 = read, 3 = probe. A read of slot mnt_index returns the virtual page in bits 31:12 of mnt_rd_hi with bits 11:0 zero, and returns the full stored low word on mnt_rd_lo.
- R3: A probe compares bits 31:12 of mnt_hi with every slot and ignores bits 11:0. On a match, mnt_probe returns the slot number zero-extended. With no match it returns 0x80000000.
- R4: A write with op 1 uses the slot given by a selector. The selector is ENTRIES-1 after reset and decrements on every clock, wrapping from 0 to ENTRIES-1. The write goes to the selector value of the cycle in which the request is presented.
- R5: A lookup that matches an entry with valid (low bit 9) set returns lk_paddr = {physical page, vaddr[11:0]} and lk_nocache = low bit 11 one cycle later, with no fault raised. This holds for a load, and for a store when dirty (low bit 10) is set.
- R6: A lookup that matches no entry raises lk_miss with lk_paddr zero.
- R7: A lookup that matches an entry whose valid bit is clear raises lk_invalid with lk_paddr zero. The valid bit plays no part in the match.
- R8: A store that matches a valid entry with dirty clear raises lk_modify with lk_paddr zero. Lookups never alter the stored dirty bit.
- R9: A lookup with vaddr bit 31 set bypasses translation and returns lk_paddr = vaddr with no fault and lk_nocache zero, even when a slot holds that page. A probe for such a page reports no match.
- R10: When several slots hold the same virtual page, both lookup and probe use the lowest-numbered slot.
- R11: lk_done is high exactly one cycle after a lookup request. At most one of lk_miss, lk_invalid and lk_modify is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mnt_valid | input | 1 | Maintenance request strobe |
| mnt_op | input | 2 | Operation: 0 write indexed, 1 write hardware slot, 2 read, 3 probe |
| mnt_index | input | 6 | Slot for indexed write and read |
| mnt_hi | input | 32 | High word (virtual page in 31:12) for write and probe |
| mnt_lo | input | 32 | Low word for writes |
| mnt_done | output | 1 | Maintenance result valid |
| mnt_rd_hi | output | 32 | High word returned by read |
| mnt_rd_lo | output | 32 | Low word returned by read |
| mnt_probe | output | 32 | Probe result: slot number, or 0x80000000 on no match |
| lk_valid | input | 1 | Lookup request strobe |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_store | input | 1 | 1 = store, 0 = load |
| lk_done | output | 1 | Lookup result valid |
| lk_paddr | output | 32 | Physical address |
| lk_nocache | output | 1 | No-cache attribute of the hit entry |
| lk_miss | output | 1 | No entry matched |
| lk_invalid | output | 1 | Matched entry has valid clear |
| lk_modify | output | 1 | Store to an entry with dirty clear |

## Verification
The checker tests every cycle that results arrive one cycle after their requests and that at most one fault flag is high. It also tests that a miss carries a zero address, that a bypassed address comes back unchanged and without faults, and that a probe result is either a legal slot number or the no-match code. Three behaviours depend on stored contents and on history, so only the bench scenarios can show them. These are which physical page and attributes a hit returns, the slot chosen by the hardware selector, and the lowest-slot choice among duplicate pages.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int WORD_W     = 32;
  localparam int PAGE_SHIFT = 12;
  localparam int VPN_W      = WORD_W - PAGE_SHIFT;

  // attribute positions in the low word
  localparam int LO_NOCACHE = 11;
  localparam int LO_DIRTY   = 10;
  localparam int LO_VALID   = 9;

  localparam logic [WORD_W-1:0] PROBE_NONE = 32'h8000_0000;

  typedef enum logic [1:0] {
    OP_WR_IDX = 2'd0,
    OP_WR_HW  = 2'd1,
    OP_RD_IDX = 2'd2,
    OP_PROBE  = 2'd3
  } mnt_op_e;
endpackage

// File: rtl/xlat_victim_ctr.sv
module xlat_victim_ctr #(
  parameter int N = 64,
  localparam int W = $clog2(N)
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] slot
);
  always_ff @(posedge clk) begin
    if (rst || slot == '0) slot <= W'(N - 1);
    else                   slot <= slot - 1'b1;
  end
endmodule

// File: rtl/xlat_entry_store.sv
module xlat_entry_store #(
  parameter int N      = 64,
  parameter int VPN_W  = 20,
  parameter int WORD_W = 32,
  localparam int W = $clog2(N)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [W-1:0]               wr_slot,
  input  logic [VPN_W-1:0]           wr_vpn,
  input  logic [WORD_W-1:0]          wr_lo,
  output logic [N-1:0][VPN_W-1:0]    vpn_all,
  output logic [N-1:0][WORD_W-1:0]   lo_all
);
  // reset loads each slot with its own never-matching page
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) begin
        vpn_all[i] <= VPN_W'((1 << (VPN_W - 1)) + i);
        lo_all[i]  <= '0;
      end
    end else if (wr_en) begin
      vpn_all[wr_slot] <= wr_vpn;
      lo_all[wr_slot]  <= wr_lo;
    end
  end
endmodule

// File: rtl/xlat_match.sv
module xlat_match #(
  parameter int N     = 64,
  parameter int VPN_W = 20,
  localparam int W = $clog2(N)
) (
  input  logic [VPN_W-1:0]        query,
  input  logic [N-1:0][VPN_W-1:0] vpn_all,
  output logic                    hit,
  output logic [W-1:0]            idx
);
  logic [N-1:0] eq;

  // pages in the untranslated region never match
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign eq[g] = !query[VPN_W-1] && (vpn_all[g] == query);
  end

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (eq[i]) idx = W'(i);
    end
  end

  assign hit = |eq;
endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int SLOT_W = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mnt_valid,
  input  logic [1:0]        mnt_op,
  input  logic [SLOT_W-1:0] mnt_index,
  input  logic [31:0]       mnt_hi,
  input  logic [31:0]       mnt_lo,
  output logic              mnt_done,
  output logic [31:0]       mnt_rd_hi,
  output logic [31:0]       mnt_rd_lo,
  output logic [31:0]       mnt_probe,
  input  logic              lk_valid,
  input  logic [31:0]       lk_vaddr,
  input  logic              lk_store,
  output logic              lk_done,
  output logic [31:0]       lk_paddr,
  output logic              lk_nocache,
  output logic              lk_miss,
  output logic              lk_invalid,
  output logic              lk_modify
);
  mnt_op_e                           op;
  logic [SLOT_W-1:0]                 victim, wr_slot, pr_idx, lk_idx;
  logic                              wr_en, pr_hit, lk_hit;
  logic [ENTRIES-1:0][VPN_W-1:0]     vpn_all;
  logic [ENTRIES-1:0][WORD_W-1:0]    lo_all;
  logic [WORD_W-1:0]                 hit_lo;
  logic                              unused_bits;

  assign op      = mnt_op_e'(mnt_op);
  assign wr_en   = mnt_valid && (op == OP_WR_IDX || op == OP_WR_HW);
  assign wr_slot = (op == OP_WR_HW) ? victim : mnt_index;
  assign hit_lo  = lo_all[lk_idx];
  assign unused_bits = ^{mnt_hi[PAGE_SHIFT-1:0], hit_lo[LO_VALID-1:0]};

  xlat_victim_ctr #(.N(ENTRIES)) u_victim (
    .clk(clk), .rst(rst), .slot(victim)
  );

  xlat_entry_store #(.N(ENTRIES), .VPN_W(VPN_W), .WORD_W(WORD_W)) u_store (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_slot(wr_slot),
    .wr_vpn(mnt_hi[WORD_W-1:PAGE_SHIFT]), .wr_lo(mnt_lo),
    .vpn_all(vpn_all), .lo_all(lo_all)
  );

  xlat_match #(.N(ENTRIES), .VPN_W(VPN_W)) u_probe_cam (
    .query(mnt_hi[WORD_W-1:PAGE_SHIFT]), .vpn_all(vpn_all),
    .hit(pr_hit), .idx(pr_idx)
  );

  xlat_match #(.N(ENTRIES), .VPN_W(VPN_W)) u_lookup_cam (
    .query(lk_vaddr[WORD_W-1:PAGE_SHIFT]), .vpn_all(vpn_all),
    .hit(lk_hit), .idx(lk_idx)
  );

  // maintenance results
  always_ff @(posedge clk) begin
    if (rst) begin
      mnt_done  <= 1'b0;
      mnt_rd_hi <= '0;
      mnt_rd_lo <= '0;
      mnt_probe <= '0;
    end else begin
      mnt_done <= mnt_valid;
      if (mnt_valid && op == OP_RD_IDX) begin
        mnt_rd_hi <= {vpn_all[mnt_index], {PAGE_SHIFT{1'b0}}};
        mnt_rd_lo <= lo_all[mnt_index];
      end
      if (mnt_valid && op == OP_PROBE)
        mnt_probe <= pr_hit ? WORD_W'(pr_idx) : PROBE_NONE;
    end
  end

  // lookup results
  always_ff @(posedge clk) begin
    if (rst) begin
      lk_done    <= 1'b0;
      lk_paddr   <= '0;
      lk_nocache <= 1'b0;
      lk_miss    <= 1'b0;
      lk_invalid <= 1'b0;
      lk_modify  <= 1'b0;
    end else begin
      lk_done    <= lk_valid;
      lk_paddr   <= '0;
      lk_nocache <= 1'b0;
      lk_miss    <= 1'b0;
      lk_invalid <= 1'b0;
      lk_modify  <= 1'b0;
      if (lk_valid) begin
        if (lk_vaddr[WORD_W-1])                       lk_paddr   <= lk_vaddr;
        else if (!lk_hit)                             lk_miss    <= 1'b1;
        else if (!hit_lo[LO_VALID])                   lk_invalid <= 1'b1;
        else if (lk_store && !hit_lo[LO_DIRTY])       lk_modify  <= 1'b1;
        else begin
          lk_paddr   <= {hit_lo[WORD_W-1:PAGE_SHIFT], lk_vaddr[PAGE_SHIFT-1:0]};
          lk_nocache <= hit_lo[LO_NOCACHE];
        end
      end
    end
  end
endmodule

// File: rtl/xlat_tlb_chk.sv
module xlat_tlb_chk #(
  parameter int ENTRIES = 64
) (
  input logic        clk,
  input logic        rst,
  input logic        mnt_valid,
  input logic [1:0]  mnt_op,
  input logic        mnt_done,
  input logic [31:0] mnt_probe,
  input logic        lk_valid,
  input logic [31:0] lk_vaddr,
  input logic        lk_done,
  input logic [31:0] lk_paddr,
  input logic        lk_miss,
  input logic        lk_invalid,
  input logic        lk_modify
);
  // R2
  mnt_latency_chk: assert property (@(posedge clk) disable iff (rst)
    mnt_done == $past(mnt_valid));

  // R3
  probe_code_chk: assert property (@(posedge clk) disable iff (rst)
    (mnt_done && $past(mnt_op) == 2'd3) |->
      (mnt_probe == 32'h8000_0000 || mnt_probe < 32'(ENTRIES)));

  // R6
  miss_addr_chk: assert property (@(posedge clk) disable iff (rst)
    lk_miss |-> lk_paddr == 32'd0);

  // R9
  bypass_chk: assert property (@(posedge clk) disable iff (rst)
    (lk_done && $past(lk_vaddr[31])) |->
      (lk_paddr == $past(lk_vaddr) && !lk_miss && !lk_invalid && !lk_modify));

  // R11
  lk_latency_chk: assert property (@(posedge clk) disable iff (rst)
    lk_done == $past(lk_valid));

  // R11
  one_fault_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({lk_miss, lk_invalid, lk_modify}));
endmodule

bind xlat_tlb xlat_tlb_chk #(.ENTRIES(ENTRIES)) u_chk (
  .clk(clk), .rst(rst), .mnt_valid(mnt_valid), .mnt_op(mnt_op),
  .mnt_done(mnt_done), .mnt_probe(mnt_probe), .lk_valid(lk_valid),
  .lk_vaddr(lk_vaddr), .lk_done(lk_done), .lk_paddr(lk_paddr),
  .lk_miss(lk_miss), .lk_invalid(lk_invalid), .lk_modify(lk_modify)
);

// File: tb/xlat_tlb_test.sv
`timescale 1ns/1ps
module xlat_tlb_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mnt_valid = 1'b0;
  logic [1:0]  mnt_op = 2'd0;
  logic [5:0]  mnt_index = 6'd0;
  logic [31:0] mnt_hi = 32'd0, mnt_lo = 32'd0;
  logic        mnt_done;
  logic [31:0] mnt_rd_hi, mnt_rd_lo, mnt_probe;
  logic        lk_valid = 1'b0, lk_store = 1'b0;
  logic [31:0] lk_vaddr = 32'd0;
  logic        lk_done, lk_nocache, lk_miss, lk_invalid, lk_modify;
  logic [31:0] lk_paddr;

  int total = 0, bad = 0;
  bit ended = 0;
  logic [5:0] bctr;

  always #2 clk = ~clk;

  // selector model from R4
  always @(posedge clk) bctr <= (rst || bctr == 6'd0) ? 6'd63 : bctr - 6'd1;

  xlat_tlb uut (
    .clk(clk), .rst(rst), .mnt_valid(mnt_valid), .mnt_op(mnt_op),
    .mnt_index(mnt_index), .mnt_hi(mnt_hi), .mnt_lo(mnt_lo),
    .mnt_done(mnt_done), .mnt_rd_hi(mnt_rd_hi), .mnt_rd_lo(mnt_rd_lo),
    .mnt_probe(mnt_probe), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
    .lk_store(lk_store), .lk_done(lk_done), .lk_paddr(lk_paddr),
    .lk_nocache(lk_nocache), .lk_miss(lk_miss), .lk_invalid(lk_invalid),
    .lk_modify(lk_modify)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    chk(act === exp, req, act, exp);
  endtask

  // each op: drive at a falling edge, sample at the next one
  task automatic mnt(input logic [1:0] op, input logic [5:0] idx,
                     input logic [31:0] hi, input logic [31:0] lo);
    mnt_valid = 1'b1; mnt_op = op; mnt_index = idx; mnt_hi = hi; mnt_lo = lo;
    @(negedge clk);
    mnt_valid = 1'b0;
    chk_eq("R2 done", {31'd0, mnt_done}, 32'd1);
  endtask

  task automatic lookup(input logic [31:0] va, input bit st);
    lk_valid = 1'b1; lk_vaddr = va; lk_store = st;
    @(negedge clk);
    lk_valid = 1'b0;
    chk_eq("R11 done", {31'd0, lk_done}, 32'd1);
  endtask

  task automatic expect_lk(input string req, input logic [31:0] pa, input bit nc,
                           input bit ms, input bit inv, input bit md);
    chk_eq({req, " paddr"}, lk_paddr, pa);
    chk_eq({req, " flags"}, {28'd0, lk_nocache, lk_miss, lk_invalid, lk_modify},
           {28'd0, nc, ms, inv, md});
  endtask

  task automatic t_reset;
    chk_eq("R1 outputs", {26'd0, mnt_done, lk_done, lk_nocache, lk_miss, lk_invalid, lk_modify}, 32'd0);
    chk_eq("R1 paddr", lk_paddr, 32'd0);
    mnt(2'd2, 6'd5, 32'd0, 32'd0);
    chk_eq("R1 hi slot5", mnt_rd_hi, 32'h8000_5000);
    chk_eq("R1 lo slot5", mnt_rd_lo, 32'd0);
    mnt(2'd3, 6'd0, 32'h8000_5000, 32'd0);
    chk_eq("R1 probe reset page", mnt_probe, 32'h8000_0000);
    lookup(32'h0000_1234, 1'b0);
    expect_lk("R6 miss after reset", 32'd0, 1'b0, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_write_read;
    mnt(2'd0, 6'd7, 32'h1234_5ABC, 32'h000A_BF5A);
    mnt(2'd2, 6'd7, 32'd0, 32'd0);
    chk_eq("R2 read hi", mnt_rd_hi, 32'h1234_5000);
    chk_eq("R2 read lo", mnt_rd_lo, 32'h000A_BF5A);
  endtask

  task automatic t_probe;
    mnt(2'd3, 6'd0, 32'h1234_5FFF, 32'd0);
    chk_eq("R3 probe hit", mnt_probe, 32'd7);
    mnt(2'd3, 6'd0, 32'h0BAD_0000, 32'd0);
    chk_eq("R3 probe miss", mnt_probe, 32'h8000_0000);
  endtask

  task automatic t_hit;
    lookup(32'h1234_5678, 1'b0);
    expect_lk("R5 load hit", 32'h000A_B678, 1'b1, 1'b0, 1'b0, 1'b0);
    lookup(32'h1234_5001, 1'b1);
    expect_lk("R5 store dirty", 32'h000A_B001, 1'b1, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_invalid;
    mnt(2'd0, 6'd9, 32'h0004_2000, 32'h0007_7400);
    lookup(32'h0004_2010, 1'b0);
    expect_lk("R7 invalid", 32'd0, 1'b0, 1'b0, 1'b1, 1'b0);
    mnt(2'd3, 6'd0, 32'h0004_2000, 32'd0);
    chk_eq("R7 probe ignores valid", mnt_probe, 32'd9);
  endtask

  task automatic t_modify;
    mnt(2'd0, 6'd10, 32'h0005_0000, 32'h0009_9200);
    lookup(32'h0005_0ABC, 1'b1);
    expect_lk("R8 modify", 32'd0, 1'b0, 1'b0, 1'b0, 1'b1);
    lookup(32'h0005_0ABC, 1'b0);
    expect_lk("R8 load ok", 32'h0009_9ABC, 1'b0, 1'b0, 1'b0, 1'b0);
    mnt(2'd2, 6'd10, 32'd0, 32'd0);
    chk_eq("R8 dirty untouched", mnt_rd_lo, 32'h0009_9200);
  endtask

  task automatic t_bypass;
    mnt(2'd0, 6'd11, 32'h9000_0000, 32'h0001_1E00);
    lookup(32'h9000_0123, 1'b1);
    expect_lk("R9 bypass", 32'h9000_0123, 1'b0, 1'b0, 1'b0, 1'b0);
    mnt(2'd3, 6'd0, 32'h9000_0000, 32'd0);
    chk_eq("R9 probe unmapped", mnt_probe, 32'h8000_0000);
  endtask

  task automatic t_multi;
    mnt(2'd0, 6'd30, 32'h0007_7000, 32'h0003_0200);
    mnt(2'd0, 6'd20, 32'h0007_7000, 32'h0002_0200);
    lookup(32'h0007_7004, 1'b0);
    expect_lk("R10 lowest wins", 32'h0002_0004, 1'b0, 1'b0, 1'b0, 1'b0);
    mnt(2'd3, 6'd0, 32'h0007_7000, 32'd0);
    chk_eq("R10 probe lowest", mnt_probe, 32'd20);
    mnt(2'd0, 6'd20, 32'h8001_4000, 32'd0);
    lookup(32'h0007_7004, 1'b0);
    expect_lk("R10 next slot", 32'h0003_0004, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_random;
    logic [5:0] exp_slot;
    repeat (3) @(negedge clk);
    exp_slot = bctr;
    mnt(2'd1, 6'd0, 32'h0006_6000, 32'h0012_3600);
    mnt(2'd3, 6'd0, 32'h0006_6000, 32'd0);
    chk_eq("R4 hw slot", mnt_probe, {26'd0, exp_slot});
    while (bctr != 6'd0) @(negedge clk);
    mnt(2'd1, 6'd0, 32'h0006_7000, 32'h0012_4600);
    mnt(2'd1, 6'd0, 32'h0006_8000, 32'h0012_5600);
    mnt(2'd3, 6'd0, 32'h0006_7000, 32'd0);
    chk_eq("R4 slot zero", mnt_probe, 32'd0);
    mnt(2'd3, 6'd0, 32'h0006_8000, 32'd0);
    chk_eq("R4 wrap to top", mnt_probe, 32'd63);
  endtask

  task automatic finish_up;
    if (!ended) begin
      ended = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_write_read();
    t_probe();
    t_hit();
    t_invalid();
    t_modify();
    t_bypass();
    t_multi();
    t_random();
    finish_up();
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'd1, 32'd0);
    finish_up();
  end
endmodule